// File: doc/BRIEF.md
# Tagged FIFO Communication Cell

This block is a single storage cell that hardware threads share as a small first-in, first-out queue. Each request carries a view code that selects what the access does to the queue. The raw view peeks at the oldest entry, or patches the newest one. The tag view reads or edits the flag word. Two queue views push and pop, and they differ only in whether a thread that finds the queue empty (for a pop) or full (for a push) is told to stall. Two counting-semaphore views exist in the code space, but this cell is configured as a queue, so they are inert.

A thread told to stall is remembered in a waiter bitmask, one bit per thread ID. The next queue access that goes through raises a wake pulse carrying the whole mask, and then clears the mask. The scheduler uses that pulse to retry the stalled threads. Each request gets exactly one response, registered one cycle later. The response carries the read data, a block flag and the wake mask.

Top module: `itc_fifo_cell`

## Requirements
- R1: After reset the tag view returns E=1 (bit 0), F=0 (bit 1), T=0 (bit 16), FIFO=1 (bit 17), entry count 0 (field from bit 18) and log2(DEPTH) in the 4-bit field at bit 28. All other bits are zero.
- R2: A tag-view write (view code 1) loads T from data bit 16, E from bit 0 and F from bit 1. When the loaded E is 1, the entry count becomes 0. The read pointer is unchanged.
- R3: A pop (view code 2 or 3, read) always clears F. When it is not blocked:
  - With count > 0, it returns the oldest entry, advances the read pointer modulo DEPTH and decrements the count.
  - With count = 0, it returns 0.
  - If the count is then 0, E is set.
- R4: A push (view code 2 or 3, write) always clears E. When it is not blocked:
  - With count < DEPTH, it stores the data at (read pointer + count) mod DEPTH and increments the count.
  - With count = DEPTH, the data is dropped.
  - If the count is then DEPTH, F is set.
- R5: In the blocking view (code 2), a pop with E=1 or a push with F=1 responds with block=1 and read data 0. It adds the requester's bit to the waiter mask and changes nothing else (apart from the F or E clear of R3 and R4).
- R6: A queue access that is not blocked, made while the waiter mask is non-zero, shows the whole mask on wake_mask for that one response and clears the mask. Otherwise wake_mask is 0.
- R7: A raw-view read (code 0) returns the entry at the read pointer and does not pop. A raw-view write overwrites the most recently pushed entry when count > 0, and is ignored when count = 0.
- R8: View codes 4 to 7 return 0. They cause no block and no wake, and change no state.
- R9: Every accepted request gets rsp_valid exactly one cycle later. Write responses carry read data 0. rsp_valid is 0 in cycles that follow no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 3 | View code (0 raw, 1 tag, 2 blocking queue, 3 try queue, 4-7 semaphore/unused) |
| req_tid | input | TIDW (3) | Requesting thread ID |
| req_wdata | input | DW (64) | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DW (64) | Read data |
| rsp_block | output | 1 | Requester must stall and retry later |
| wake_mask | output | NTHR (8) | One-cycle pulse of the threads to wake |

## Verification
Two functions can fall in the same cycle. In the first, a queue access that moves data also releases the waiters, so a push or pop and a wake land together. The bench provokes this by stalling several threads on an empty or full queue, then issuing a try-view access from a different thread. It checks that the moved data, the updated tag word and the wake mask all match the bench's reference model in that one response. In the second, a blocked access clears F or E while adding a waiter. Control reads right after such an access confirm the flag clear and the unchanged count.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;
  typedef enum logic [2:0] {
    VW_RAW     = 3'd0,
    VW_TAG     = 3'd1,
    VW_Q_BLOCK = 3'd2,
    VW_Q_TRY   = 3'd3
  } cell_view_e;

  typedef struct packed {
    logic trap;
    logic full;
    logic empty;
  } cell_flags_t;

  localparam int TAGB_EMPTY = 0;
  localparam int TAGB_FULL  = 1;
  localparam int TAGB_TRAP  = 16;
  localparam int TAGB_QMODE = 17;
  localparam int TAGB_COUNT = 18;
  localparam int TAGB_DCODE = 28;
  localparam int DCODE_W    = 4;
endpackage

// File: rtl/itc_cell_store.sv
module itc_cell_store #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata_q
);
  logic [DW-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
    rdata_q <= slots[raddr];
  end
endmodule

// File: rtl/itc_cell_waiters.sv
module itc_cell_waiters #(
  parameter int NTHR = 8,
  parameter int TIDW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            add_req,
  input  logic [TIDW-1:0] add_tid,
  input  logic            wake_req,
  output logic            any_waiting,
  output logic [NTHR-1:0] wake_q
);
  logic [NTHR-1:0] pend_q;

  assign any_waiting = |pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      wake_q <= '0;
    end else begin
      wake_q <= '0;
      if (wake_req) begin
        wake_q <= pend_q;
        pend_q <= '0;
      end else if (add_req) begin
        pend_q[add_tid] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/itc_cell_ctrl.sv
module itc_cell_ctrl
  import itc_cell_pkg::*;
#(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [2:0]    req_view,
  input  logic [DW-1:0] req_wdata,
  input  logic          waiters_any,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] mem_raddr,
  output logic          hold_req,
  output logic          wake_req,
  output logic          rsp_valid_q,
  output logic          rsp_block_q,
  output logic          use_mem_q,
  output logic [DW-1:0] aux_q
);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_NEAR = CW'(DEPTH - 1);

  cell_flags_t   flg_q, flg_n;
  logic [AW-1:0] rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          use_mem_n;
  logic [DW-1:0] aux_n;
  logic [DW-1:0] tag_word;
  logic [AW-1:0] tail_idx;
  logic          is_blocking;

  assign tail_idx    = rp_q + cnt_q[AW-1:0];
  assign mem_raddr   = rp_q;
  assign mem_wdata   = req_wdata;
  assign is_blocking = (req_view == VW_Q_BLOCK);

  always_comb begin
    tag_word                        = '0;
    tag_word[TAGB_EMPTY]            = flg_q.empty;
    tag_word[TAGB_FULL]             = flg_q.full;
    tag_word[TAGB_TRAP]             = flg_q.trap;
    tag_word[TAGB_QMODE]            = 1'b1;
    tag_word[TAGB_COUNT +: CW]      = cnt_q;
    tag_word[TAGB_DCODE +: DCODE_W] = DCODE_W'(AW);
  end

  always_comb begin
    flg_n     = flg_q;
    rp_n      = rp_q;
    cnt_n     = cnt_q;
    mem_we    = 1'b0;
    mem_waddr = tail_idx;
    hold_req  = 1'b0;
    wake_req  = 1'b0;
    use_mem_n = 1'b0;
    aux_n     = '0;
    if (req_valid) begin
      case (req_view)
        VW_RAW: begin
          if (req_write) begin
            if (cnt_q != '0) begin
              mem_we    = 1'b1;
              mem_waddr = tail_idx - AW'(1);
            end
          end else begin
            use_mem_n = 1'b1;
          end
        end
        VW_TAG: begin
          if (req_write) begin
            flg_n.trap  = req_wdata[TAGB_TRAP];
            flg_n.empty = req_wdata[TAGB_EMPTY];
            flg_n.full  = req_wdata[TAGB_FULL];
            if (req_wdata[TAGB_EMPTY]) cnt_n = '0;
          end else begin
            aux_n = tag_word;
          end
        end
        VW_Q_BLOCK, VW_Q_TRY: begin
          if (!req_write) begin
            flg_n.full = 1'b0;
            if (flg_q.empty && is_blocking) begin
              hold_req = 1'b1;
            end else begin
              wake_req = waiters_any;
              if (cnt_q != '0) begin
                use_mem_n = 1'b1;
                rp_n      = rp_q + AW'(1);
                cnt_n     = cnt_q - CW'(1);
              end
              if (cnt_q <= CW'(1)) flg_n.empty = 1'b1;
            end
          end else begin
            flg_n.empty = 1'b0;
            if (flg_q.full && is_blocking) begin
              hold_req = 1'b1;
            end else begin
              wake_req = waiters_any;
              if (cnt_q < CNT_MAX) begin
                mem_we = 1'b1;
                cnt_n  = cnt_q + CW'(1);
              end
              if (cnt_q >= CNT_NEAR) flg_n.full = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q       <= '{trap: 1'b0, full: 1'b0, empty: 1'b1};
      rp_q        <= '0;
      cnt_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_block_q <= 1'b0;
      use_mem_q   <= 1'b0;
      aux_q       <= '0;
    end else begin
      flg_q       <= flg_n;
      rp_q        <= rp_n;
      cnt_q       <= cnt_n;
      rsp_valid_q <= req_valid;
      rsp_block_q <= hold_req;
      use_mem_q   <= use_mem_n;
      aux_q       <= aux_n;
    end
  end
endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell #(
  parameter int DW    = 64,
  parameter int DEPTH = 8,
  parameter int NTHR  = 8,
  parameter int TIDW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [2:0]      req_view,
  input  logic [TIDW-1:0] req_tid,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_block,
  output logic [NTHR-1:0] wake_mask
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [AW-1:0] mem_raddr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_q;
  logic [DW-1:0] aux_q;
  logic          use_mem_q;
  logic          hold_req;
  logic          wake_req;
  logic          waiters_any;

  itc_cell_ctrl #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_view(req_view),
    .req_wdata(req_wdata), .waiters_any(waiters_any),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .hold_req(hold_req), .wake_req(wake_req),
    .rsp_valid_q(rsp_valid), .rsp_block_q(rsp_block),
    .use_mem_q(use_mem_q), .aux_q(aux_q)
  );

  itc_cell_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata_q(mem_q)
  );

  itc_cell_waiters #(.NTHR(NTHR), .TIDW(TIDW)) u_wait (
    .clk(clk), .rst(rst),
    .add_req(hold_req), .add_tid(req_tid), .wake_req(wake_req),
    .any_waiting(waiters_any), .wake_q(wake_mask)
  );

  assign rsp_rdata = use_mem_q ? mem_q : aux_q;
endmodule

// File: rtl/itc_cell_checks.sv
module itc_cell_checks #(
  parameter int DW   = 64,
  parameter int NTHR = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic [2:0]      req_view,
  input logic            rsp_valid,
  input logic [DW-1:0]   rsp_rdata,
  input logic            rsp_block,
  input logic [NTHR-1:0] wake_mask
);
  p_rsp_follow_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_rsp_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_write_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_rdata == '0));
  p_block_view_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_view != 3'd2) |=> !rsp_block);
  p_block_no_wake_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_block |-> (wake_mask == '0));
  p_wake_single_r6: assert property (@(posedge clk) disable iff (rst)
    (wake_mask != '0) |=> (wake_mask == '0));
  p_sem_inert_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_view[2]) |=> (rsp_rdata == '0 && wake_mask == '0 && !rsp_block));
  p_tag_no_wake_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_view <= 3'd1) |=> (wake_mask == '0));
endmodule

bind itc_fifo_cell itc_cell_checks #(.DW(DW), .NTHR(NTHR)) u_checks (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_view(req_view), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_block(rsp_block), .wake_mask(wake_mask)
);

// File: tb/itc_fifo_cell_bench.sv
`timescale 1ns/1ps
module itc_fifo_cell_bench;
  localparam int DW = 64, DEPTH = 8, NTHR = 8, TIDW = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]      req_view = '0;
  logic [TIDW-1:0] req_tid = '0;
  logic [DW-1:0]   req_wdata = '0;
  logic            rsp_valid, rsp_block;
  logic [DW-1:0]   rsp_rdata;
  logic [NTHR-1:0] wake_mask;

  int checks = 0, errors = 0;

  logic [DW-1:0] m_mem [DEPTH];
  int            m_rp, m_cnt;
  bit            m_e, m_f, m_t;
  logic [NTHR-1:0] m_wait;

  always #10 clk = ~clk;

  itc_fifo_cell #(.DW(DW), .DEPTH(DEPTH), .NTHR(NTHR)) u_itc_fifo_cell (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_view(req_view), .req_tid(req_tid), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_block(rsp_block),
    .wake_mask(wake_mask)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_tag();
    logic [DW-1:0] w = '0;
    w[0] = m_e; w[1] = m_f; w[16] = m_t; w[17] = 1'b1;
    w[18 +: 4] = 4'(m_cnt);
    w[28 +: 4] = 4'd3;
    return w;
  endfunction

  task automatic access(input bit wr, input int view, input int tid, input logic [DW-1:0] wd);
    logic [DW-1:0]   e_rd = '0;
    bit              e_blk = 0;
    logic [NTHR-1:0] e_wk = '0;
    string           tg = "R8";
    case (view)
      0: begin
        tg = "R7";
        if (wr) begin
          if (m_cnt > 0) m_mem[(m_rp + m_cnt - 1) % DEPTH] = wd;
        end else e_rd = m_mem[m_rp];
      end
      1: begin
        tg = "R2";
        if (wr) begin
          m_t = wd[16]; m_e = wd[0]; m_f = wd[1];
          if (wd[0]) m_cnt = 0;
        end else e_rd = model_tag();
      end
      2, 3: begin
        if (!wr) begin
          tg = "R3";
          m_f = 0;
          if (m_e && view == 2) begin
            e_blk = 1; m_wait[tid] = 1'b1; tg = "R5";
          end else begin
            if (m_wait != 0) begin e_wk = m_wait; m_wait = '0; end
            if (m_cnt > 0) begin
              e_rd = m_mem[m_rp]; m_rp = (m_rp + 1) % DEPTH; m_cnt--;
            end
            if (m_cnt == 0) m_e = 1;
          end
        end else begin
          tg = "R4";
          m_e = 0;
          if (m_f && view == 2) begin
            e_blk = 1; m_wait[tid] = 1'b1; tg = "R5";
          end else begin
            if (m_wait != 0) begin e_wk = m_wait; m_wait = '0; end
            if (m_cnt < DEPTH) begin
              m_mem[(m_rp + m_cnt) % DEPTH] = wd; m_cnt++;
            end
            if (m_cnt == DEPTH) m_f = 1;
          end
        end
      end
      default: ;
    endcase
    req_valid = 1'b1; req_write = wr; req_view = 3'(view);
    req_tid = TIDW'(tid); req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rsp_valid", DW'(rsp_valid), DW'(1));
    chk({tg, " rdata"}, rsp_rdata, e_rd);
    chk("R5 block", DW'(rsp_block), DW'(e_blk));
    chk("R6 wake", DW'(wake_mask), DW'(e_wk));
  endtask

  task automatic tag_check(input string req);
    logic [DW-1:0] exp = model_tag();
    req_valid = 1'b1; req_write = 1'b0; req_view = 3'd1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, rsp_rdata, exp);
  endtask

  function automatic logic [DW-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_rp = 0; m_cnt = 0; m_e = 1; m_f = 0; m_t = 0; m_wait = '0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle rsp_valid", DW'(rsp_valid), DW'(0));
    chk("R6 reset wake", DW'(wake_mask), DW'(0));
    // R1: reset tag word
    chk("R1 reset tag", model_tag(), 64'h3002_0001);
    tag_check("R1 reset tag");

    // R4: fill the queue, then push beyond full (dropped)
    for (int i = 0; i < DEPTH; i++) access(1, 3, 0, 64'hA000 + i);
    tag_check("R4 full tag");
    access(1, 3, 1, 64'hDEAD);
    // R5: blocking push on a full queue
    access(1, 2, 2, 64'hBEEF);
    tag_check("R5 tag after blocked push");
    // R7: peek and patch newest
    access(0, 0, 0, '0);
    access(1, 0, 0, 64'h5A5A);
    // R6: pop together with wake of thread 2
    access(0, 3, 3, '0);
    for (int i = 0; i < DEPTH; i++) access(0, 3, 0, '0);
    tag_check("R3 empty tag");
    // R7: raw write ignored while empty
    access(1, 0, 0, 64'h7777);
    access(0, 0, 0, '0);
    // R5/R6: two blocked readers released by one push
    access(0, 2, 5, '0);
    access(0, 2, 6, '0);
    access(1, 3, 1, 64'h1234);
    access(0, 2, 4, '0);
    // R8: semaphore and unused views are inert
    access(1, 3, 0, 64'h9999);
    for (int v = 4; v < 8; v++) begin
      access(0, v, 0, '0);
      access(1, v, 0, 64'hFFFF);
    end
    tag_check("R8 tag unchanged");
    // R2: control write with E set clears the count
    access(1, 3, 0, 64'h4444);
    access(1, 1, 0, 64'h0001_0003);
    tag_check("R2 tag after write");
    access(1, 1, 0, 64'h0);
    access(0, 3, 0, '0);
    tag_check("R3 empty after pop of zero count");

    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 20;
      int tid = $urandom % NTHR;
      if (r < 2)       access(0, 0, tid, '0);
      else if (r < 3)  access(1, 0, tid, rnd64());
      else if (r < 4)  access(0, 1, tid, '0);
      else if (r < 5 && ($urandom % 4 == 0)) access(1, 1, tid, rnd64());
      else if (r < 9)  access(1, 3, tid, rnd64());
      else if (r < 13) access(0, 3, tid, '0);
      else if (r < 15) access(1, 2, tid, rnd64());
      else if (r < 17) access(0, 2, tid, '0);
      else if (r < 19) access($urandom % 2, 4 + $urandom % 4, tid, rnd64());
      else begin
        @(negedge clk);
        chk("R9 idle rsp_valid", DW'(rsp_valid), DW'(0));
      end
    end
    tag_check("R1 final tag");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule